// File: doc/BRIEF.md
# Timer Channel with Waveform Outputs

This block is one 16-bit timer channel. It counts ticks of a counting clock picked from a set of prescaled versions of the master clock. A burst input gates that clock. The channel runs in one of two modes. In capture mode, two capture strobes copy the counter into two capture registers. In waveform mode, three compare values and two triggers drive two waveform output pins.

A small state machine holds the counting state. It has three states: `CS_STOP` (the clock is off), `CS_UP` and `CS_DOWN`. The transitions are:

- `CS_STOP` to `CS_UP` on the enable command.
- Any state to `CS_STOP` on the disable command.
- `CS_UP` to `CS_DOWN` when an up/down mode reaches its top value.
- `CS_DOWN` to `CS_UP` when the count reaches zero, or when a trigger is applied.

A trigger is either the software trigger or the external event. It is applied on the next counting tick. If the tick is held back, the trigger is kept pending until the tick arrives.

Each waveform output is a two-state machine, `LVL_LO` and `LVL_HI`. On each cycle it applies the action of the highest-priority event that is active and whose action is not "none". The action is set, clear or toggle. All registers are plain input ports; the block has no bus decoding and no interrupts.

Top module: `tmr_wave_channel`

## Requirements
- R1: After reset the count is 0, both waveform outputs are 0, both capture registers are 0, the state is `CS_STOP` (`running_o`=0) and `dir_down_o` is 0.
- R2: A pulse on `clk_en_i` starts counting, and a pulse on `clk_dis_i` stops it. A stopped counter holds its value. The software trigger has no effect on the count or on the outputs while the counter is stopped.
- R3: `clk_sel_i` picks the tick rate: 0 ticks on every master cycle, 1 every 2 cycles, 2 every 8, 3 every 32, and 4 or above every 128. All rates come from one prescaler that is updated on the rising master edge.
- R4: While `burst_i` is 1, no tick occurs and the count does not change.
- R5: A trigger (the software trigger while running, or `ext_evt_i`) sets the count to 0 on the next tick. A trigger that arrives while ticks are held back is kept pending and applied on the first tick after that.
- R6: A capture strobe in capture mode (`wave_mode_i`=0) loads the current count into its register. It loads 0 instead if a trigger is pending or is recognised in the same cycle.
- R7: Waveform select 0 counts up and wraps at the maximum. Select 2 counts up and returns to 0 on the tick after the count equals `rc_i`.
- R8: Selects 1 and 3 count up and then down. The turnaround value is the maximum for select 1 and `rc_i` for select 3. `dir_down_o` is 1 while counting down, and the count turns back up at 0.
- R9: In the up/down selects, a trigger sets the count to 0 and restores the up direction.
- R10: Each output has an 8-bit action field. Bits [1:0] are for the software trigger, [3:2] for the external event, [5:4] for the RC compare, and [7:6] for the RA compare (TIOA) or the RB compare (TIOB). The codes are 0 = none, 1 = set, 2 = clear, 3 = toggle.
- R11: When events coincide, the priority is: software trigger, then external event, then RC compare, then RA or RB compare. A source whose action is none never blocks a lower-priority source.
- R12: TIOB follows the same rules as TIOA, with the RB compare in place of the RA compare.
- R13: A compare event occurs on a tick in waveform mode when the count before the tick equals the compare value. The outputs change only in waveform mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| clk_en_i | input | 1 | Clock enable command pulse |
| clk_dis_i | input | 1 | Clock disable command pulse |
| swtrg_i | input | 1 | Software trigger pulse |
| ext_evt_i | input | 1 | External event trigger pulse |
| burst_i | input | 1 | Tick gate, active high |
| clk_sel_i | input | 3 | Counting clock select |
| wave_mode_i | input | 1 | 1 = waveform mode, 0 = capture mode |
| wsel_i | input | 2 | Waveform counting select |
| ra_i | input | 16 | Compare value A |
| rb_i | input | 16 | Compare value B |
| rc_i | input | 16 | Compare value C |
| act_a_i | input | 8 | Action field for TIOA |
| act_b_i | input | 8 | Action field for TIOB |
| cap_a_i | input | 1 | Capture strobe A |
| cap_b_i | input | 1 | Capture strobe B |
| count_o | output | 16 | Counter value |
| dir_down_o | output | 1 | Counting down |
| running_o | output | 1 | Counting clock is enabled |
| cap_ra_o | output | 16 | Capture register A |
| cap_rb_o | output | 16 | Capture register B |
| tioa_o | output | 1 | Waveform output A |
| tiob_o | output | 1 | Waveform output B |

## Verification
On every cycle, assertions check four things:

- Without a tick, the count never changes, and a stopped counter stays frozen.
- A tick that meets a trigger, new or pending, always leaves the count at 0 in the up state.
- A down step moves the count by exactly one.
- An output with no active event keeps its level, and a capture taken with a trigger pending holds zero.

Only the scenarios can show the values that come out of a sequence of actions:

- The prescaler rates.
- The turnaround point in up/down counting.
- The winning action among coincident events, and the level that results.
- A pending trigger taking effect only once the burst gate is released.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        WS_UP      = 2'd0,
        WS_UPDN    = 2'd1,
        WS_UP_RC   = 2'd2,
        WS_UPDN_RC = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        CS_STOP = 2'd0,
        CS_UP   = 2'd1,
        CS_DOWN = 2'd2
    } cnt_state_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    // event source slots, lowest index = highest priority
    localparam int NUM_SRC = 4;
    localparam int SRC_SW  = 0;
    localparam int SRC_EXT = 1;
    localparam int SRC_RC  = 2;
    localparam int SRC_CMP = 3;

endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
    parameter int NUM_SEL = 5,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             run_i,
    input  logic             burst_i,
    output logic             tick_o
);

    // source k>0 divides by 2^(2k-1)
    localparam int PRE_W = (NUM_SEL > 2) ? (2 * NUM_SEL - 3) : 1;

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_SEL-1:0] src;
    logic [SEL_W-1:0]   sel_idx;

    // every source derives from this one register on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign src[0] = 1'b1;

    generate
        for (genvar k = 1; k < NUM_SEL; k++) begin : g_src
            assign src[k] = &pre_q[2*k-2:0];
        end
    endgenerate

    always_comb begin
        if (sel_i >= SEL_W'(NUM_SEL)) sel_idx = SEL_W'(NUM_SEL - 1);
        else                          sel_idx = sel_i;
    end

    assign tick_o = src[sel_idx] & run_i & ~burst_i;

endmodule

// File: rtl/tmr_cnt_fsm.sv
module tmr_cnt_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             trig_i,
    input  logic             en_i,
    input  logic             dis_i,
    input  logic             updn_i,
    input  logic             uprc_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] rc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             down_o,
    output logic             pend_o
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             pend_q, pend_d;
    logic             zero_req;

    assign zero_req = trig_i | pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_STOP;
            count_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            pend_q  <= pend_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        pend_d  = pend_q;
        unique case (state_q)
            CS_STOP: begin
                if (trig_i) pend_d = 1'b1;
                if (en_i)   state_d = CS_UP;
            end
            CS_UP: begin
                if (tick_i) begin
                    if (zero_req) begin
                        count_d = '0;
                        pend_d  = 1'b0;
                    end else if (updn_i && (count_q >= top_i)) begin
                        state_d = CS_DOWN;
                        count_d = (count_q == '0) ? '0 : count_q - 1'b1;
                    end else if (uprc_i && (count_q == rc_i)) begin
                        count_d = '0;
                    end else begin
                        count_d = count_q + 1'b1;
                    end
                end else if (trig_i) begin
                    pend_d = 1'b1;
                end
            end
            CS_DOWN: begin
                if (tick_i) begin
                    if (zero_req) begin
                        count_d = '0;
                        pend_d  = 1'b0;
                        state_d = CS_UP;
                    end else if (count_q == '0) begin
                        count_d = CNT_W'(1);
                        state_d = CS_UP;
                    end else begin
                        count_d = count_q - 1'b1;
                    end
                end else if (trig_i) begin
                    pend_d = 1'b1;
                end
            end
            default: state_d = CS_STOP;
        endcase
        if (dis_i) state_d = CS_STOP;
    end

    // outputs
    always_comb begin
        count_o   = count_q;
        running_o = (state_q != CS_STOP);
        down_o    = (state_q == CS_DOWN);
        pend_o    = pend_q;
    end

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_q));

    assert_stop_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_STOP) |=> $stable(count_q));

    assert_trig_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (trig_i || pend_q)) |=> (count_q == '0));

    assert_trig_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (trig_i || pend_q) && !dis_i) |=> (state_q == CS_UP));

    assert_down_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_DOWN && tick_i && !trig_i && !pend_q && count_q != '0)
        |=> (count_q == CNT_W'($past(count_q) - 1'b1)));

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [2*NUM_SRC-1:0] act_i,
    output logic               tio_o
);

    lvl_e lvl_q, lvl_d;
    act_e win;

    // highest priority active source with a real action
    always_comb begin
        win = ACT_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (evt_i[i] && (act_e'(act_i[2*i +: 2]) != ACT_NONE))
                win = act_e'(act_i[2*i +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LO;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        lvl_d = lvl_q;
        unique case (win)
            ACT_NONE: lvl_d = lvl_q;
            ACT_SET:  lvl_d = LVL_HI;
            ACT_CLR:  lvl_d = LVL_LO;
            ACT_TGL:  lvl_d = (lvl_q == LVL_HI) ? LVL_LO : LVL_HI;
            default:  lvl_d = lvl_q;
        endcase
    end

    assign tio_o = (lvl_q == LVL_HI);

    assert_quiet_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> $stable(lvl_q));

    assert_sw_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[SRC_SW] && act_i[1:0] == 2'd1) |=> (lvl_q == LVL_HI));

endmodule

// File: rtl/tmr_wave_channel.sv
module tmr_wave_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_SEL = 5,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_i,
    input  logic             clk_dis_i,
    input  logic             swtrg_i,
    input  logic             ext_evt_i,
    input  logic             burst_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic             wave_mode_i,
    input  logic [1:0]       wsel_i,
    input  logic [CNT_W-1:0] ra_i,
    input  logic [CNT_W-1:0] rb_i,
    input  logic [CNT_W-1:0] rc_i,
    input  logic [7:0]       act_a_i,
    input  logic [7:0]       act_b_i,
    input  logic             cap_a_i,
    input  logic             cap_b_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             running_o,
    output logic [CNT_W-1:0] cap_ra_o,
    output logic [CNT_W-1:0] cap_rb_o,
    output logic             tioa_o,
    output logic             tiob_o
);

    localparam int NUM_OUT = 2;

    logic             tick;
    logic             running;
    logic             pend;
    logic             sw_acc;
    logic             trig;
    logic             updn, uprc;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] count;
    logic             cmp_a, cmp_b, cmp_c;
    logic             cap_zero;
    logic [CNT_W-1:0] cap_ra_q, cap_rb_q;
    wsel_e            wsel;

    logic [NUM_SRC-1:0]   evt_vec [NUM_OUT];
    logic [2*NUM_SRC-1:0] act_vec [NUM_OUT];
    logic [NUM_OUT-1:0]   tio_vec;

    assign wsel   = wsel_e'(wsel_i);
    assign sw_acc = swtrg_i & running;
    assign trig   = sw_acc | ext_evt_i;
    assign updn   = wave_mode_i & ((wsel == WS_UPDN) | (wsel == WS_UPDN_RC));
    assign uprc   = wave_mode_i & (wsel == WS_UP_RC);
    assign top    = (wsel == WS_UPDN_RC) ? rc_i : '1;

    tmr_clk_sel #(
        .NUM_SEL (NUM_SEL),
        .SEL_W   (SEL_W)
    ) u_clk_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (clk_sel_i),
        .run_i   (running),
        .burst_i (burst_i),
        .tick_o  (tick)
    );

    tmr_cnt_fsm #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .trig_i    (trig),
        .en_i      (clk_en_i),
        .dis_i     (clk_dis_i),
        .updn_i    (updn),
        .uprc_i    (uprc),
        .top_i     (top),
        .rc_i      (rc_i),
        .count_o   (count),
        .running_o (running),
        .down_o    (dir_down_o),
        .pend_o    (pend)
    );

    // compare events on ticks in waveform mode
    assign cmp_a = wave_mode_i & tick & (count == ra_i);
    assign cmp_b = wave_mode_i & tick & (count == rb_i);
    assign cmp_c = wave_mode_i & tick & (count == rc_i);

    always_comb begin
        evt_vec[0] = '0;
        evt_vec[1] = '0;
        evt_vec[0][SRC_SW]  = wave_mode_i & sw_acc;
        evt_vec[0][SRC_EXT] = wave_mode_i & ext_evt_i;
        evt_vec[0][SRC_RC]  = cmp_c;
        evt_vec[0][SRC_CMP] = cmp_a;
        evt_vec[1][SRC_SW]  = wave_mode_i & sw_acc;
        evt_vec[1][SRC_EXT] = wave_mode_i & ext_evt_i;
        evt_vec[1][SRC_RC]  = cmp_c;
        evt_vec[1][SRC_CMP] = cmp_b;
        act_vec[0] = act_a_i;
        act_vec[1] = act_b_i;
    end

    generate
        for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
            tmr_wave_out u_out (
                .clk   (clk),
                .rst_n (rst_n),
                .evt_i (evt_vec[o]),
                .act_i (act_vec[o]),
                .tio_o (tio_vec[o])
            );
        end
    endgenerate

    // capture registers
    assign cap_zero = pend | trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ra_q <= '0;
            cap_rb_q <= '0;
        end else if (!wave_mode_i) begin
            if (cap_a_i) cap_ra_q <= cap_zero ? '0 : count;
            if (cap_b_i) cap_rb_q <= cap_zero ? '0 : count;
        end
    end

    assign count_o   = count;
    assign running_o = running;
    assign cap_ra_o  = cap_ra_q;
    assign cap_rb_o  = cap_rb_q;
    assign tioa_o    = tio_vec[0];
    assign tiob_o    = tio_vec[1];

    assert_cap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a_i && !wave_mode_i && (pend || trig)) |=> (cap_ra_o == '0));

    assert_cap_mode_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wave_mode_i |=> ($stable(cap_ra_o) && $stable(cap_rb_o)));

endmodule

// File: tb/tmr_wave_channel_tb.sv
module tmr_wave_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_i = 0, clk_dis_i = 0, swtrg_i = 0, ext_evt_i = 0, burst_i = 0;
    logic [2:0]  clk_sel_i = 0;
    logic        wave_mode_i = 0;
    logic [1:0]  wsel_i = 0;
    logic [15:0] ra_i = 16'hFFFF, rb_i = 16'hFFFF, rc_i = 16'hFFFF;
    logic [7:0]  act_a_i = 0, act_b_i = 0;
    logic        cap_a_i = 0, cap_b_i = 0;
    logic [15:0] count_o, cap_ra_o, cap_rb_o;
    logic        dir_down_o, running_o, tioa_o, tiob_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wave_channel u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en_i), .clk_dis_i(clk_dis_i),
        .swtrg_i(swtrg_i), .ext_evt_i(ext_evt_i), .burst_i(burst_i),
        .clk_sel_i(clk_sel_i), .wave_mode_i(wave_mode_i), .wsel_i(wsel_i),
        .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i), .act_a_i(act_a_i), .act_b_i(act_b_i),
        .cap_a_i(cap_a_i), .cap_b_i(cap_b_i), .count_o(count_o),
        .dir_down_o(dir_down_o), .running_o(running_o), .cap_ra_o(cap_ra_o),
        .cap_rb_o(cap_rb_o), .tioa_o(tioa_o), .tiob_o(tiob_o)
    );

    // {action field, swtrg, ext_evt, expected tioa}
    localparam logic [10:0] VEC [0:7] = '{
        {8'h01, 1'b1, 1'b0, 1'b1},
        {8'h06, 1'b1, 1'b1, 1'b0},
        {8'h04, 1'b1, 1'b1, 1'b1},
        {8'h0B, 1'b1, 1'b1, 1'b0},
        {8'h0C, 1'b0, 1'b1, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b1},
        {8'h0E, 1'b0, 1'b1, 1'b0},
        {8'h03, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sw();
        swtrg_i = 1; edges(1); swtrg_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        edges(2);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 tioa", tioa_o, 0);
        chk("R1 tiob", tiob_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 caps", {cap_ra_o, cap_rb_o}, 0);
        chk("R1 dir", dir_down_o, 0);
        rst_n = 1;
        edges(1);

        // R2 stopped: software trigger ignored
        wave_mode_i = 1; act_a_i = 8'h03;
        pulse_sw();
        edges(4);
        chk("R2 stopped tioa", tioa_o, 0);
        chk("R2 stopped count", count_o, 0);
        act_a_i = 0;

        // R2/R3 enable, rate 1
        clk_en_i = 1; edges(1); clk_en_i = 0;
        chk("R2 running", running_o, 1);
        edges(10);
        chk("R3 sel0 count", count_o, 10);

        // R3 slower rates
        clk_sel_i = 1; c = count_o; edges(20);
        chk("R3 sel1 count", count_o, 32'(c + 16'd10));
        clk_sel_i = 2; c = count_o; edges(64);
        chk("R3 sel2 count", count_o, 32'(c + 16'd8));
        clk_sel_i = 0;

        // R4 burst gate, R5 pending trigger
        burst_i = 1; c = count_o; edges(10);
        chk("R4 burst hold", count_o, c);
        ext_evt_i = 1; edges(1); ext_evt_i = 0;
        edges(3);
        chk("R5 pending no change", count_o, c);
        burst_i = 0; edges(1);
        chk("R5 pending applied", count_o, 0);
        edges(1);
        chk("R5 resume", count_o, 1);

        // R2 disable freezes, swtrg ignored
        clk_dis_i = 1; edges(1); clk_dis_i = 0;
        c = count_o;
        chk("R2 stopped flag", running_o, 0);
        act_a_i = 8'h03;
        pulse_sw();
        edges(4);
        chk("R2 frozen count", count_o, c);
        chk("R2 ignored trig tioa", tioa_o, 0);
        act_a_i = 0;
        clk_en_i = 1; edges(1); clk_en_i = 0;

        // R10/R11 action table
        for (int i = 0; i < 8; i++) begin
            act_a_i = VEC[i][10:3];
            swtrg_i = VEC[i][2];
            ext_evt_i = VEC[i][1];
            edges(1);
            swtrg_i = 0; ext_evt_i = 0;
            chk($sformatf("R11 R10 vector %0d", i), tioa_o, VEC[i][0]);
        end
        act_a_i = 0;

        // R12 TIOB
        act_b_i = 8'h01;
        pulse_sw();
        chk("R12 tiob set", tiob_o, 1);
        act_b_i = 8'h80; rb_i = 16'd4;
        edges(6);
        chk("R12 R13 rb compare clear", tiob_o, 0);
        act_b_i = 0;

        // R11/R7: RC clear beats RA set, select 2
        wsel_i = 2; rc_i = 3; ra_i = 3; act_a_i = 8'h61;
        pulse_sw();
        chk("R10 sw set", tioa_o, 1);
        edges(3);
        chk("R7 at rc", count_o, 3);
        chk("R11 before compare", tioa_o, 1);
        edges(1);
        chk("R11 rc beats ra", tioa_o, 0);
        chk("R7 rc reset", count_o, 0);
        act_a_i = 0;

        // R8/R9 up/down with rc turnaround
        wsel_i = 3; rc_i = 5;
        pulse_sw();
        chk("R9 trig zero", count_o, 0);
        edges(8);
        chk("R8 down count", count_o, 2);
        chk("R8 down dir", dir_down_o, 1);
        pulse_sw();
        chk("R9 updn trig count", count_o, 0);
        chk("R9 updn trig dir", dir_down_o, 0);
        edges(1);
        chk("R9 counting up", count_o, 1);

        // R6 capture mode
        wave_mode_i = 0; wsel_i = 0;
        edges(3);
        c = count_o;
        cap_a_i = 1; edges(1); cap_a_i = 0;
        chk("R6 capture value", cap_ra_o, c);
        burst_i = 1; c = count_o;
        ext_evt_i = 1; edges(1); ext_evt_i = 0;
        chk("R5 burst pending count", count_o, c);
        cap_b_i = 1; edges(1); cap_b_i = 0;
        chk("R6 capture zero pending", cap_rb_o, 0);
        act_a_i = 8'h03;
        pulse_sw();
        chk("R13 capture mode tioa", tioa_o, 0);
        act_a_i = 0;
        burst_i = 0; edges(1);
        chk("R5 applied after burst", count_o, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule